// File: doc/BRIEF.md
# SPI-Mode Card Data Token Engine

This block is the card-side engine that moves block data over an SPI slave link once a command decoder has settled that a read or a write is due. For a read it streams a start token, the block bytes taken from a block buffer, and a 16-bit CRC. If the fetch has already failed, it sends a one-byte error token in place of all of that. For a write it waits for a start token, stores the block bytes into the buffer, checks the CRC that follows, answers with a one-byte data response, and then holds the output line low with busy bytes until the flash side reports that programming is done.

The SPI pins are oversampled in the system clock domain. Bytes go MSB first and are framed from the falling edge of the active-low select. In SPI mode 0 the card updates its output on falling SCK edges and samples the input on rising ones. A multi-block write session keeps accepting blocks until a stop token arrives. Busy signalling survives a release and reselection of the card: while deselected the output is tristated, and when reselected it is driven low again. A `card_busy` flag tells the command layer to reject commands during that time.

Top module: `sd_spi_token_engine`

## Requirements
- R1: After reset `spi_miso_oe`, `card_busy` and `prog_start` are 0. While selected with no transfer pending, every byte read out is 0xFF and `spi_miso_oe` is 1. Bytes are MSB first and aligned to the falling edge of `spi_cs_n`.
- R2: A read started with `rd_go` and `rd_fail`=0 sends 0xFE, then `BLK_BYTES` bytes read from buffer addresses 0 upward, then the CRC16 of those bytes, high byte first. The CRC uses polynomial 0x1021 and starts from 0. The byte after the CRC is 0xFF.
- R3: A read started with `rd_fail`=1 sends one error token and then 0xFF. The token is 0x08 when `rd_fail_range`=1 and 0x01 otherwise.
- R4: In a write, bytes received before the start token are ignored. The start token is 0xFE for a single-block write and 0xFC for a multi-block write. The `BLK_BYTES` bytes after it are written to buffer addresses 0 upward, and the next two bytes are taken as the CRC, high byte first.
- R5: The byte sent right after the CRC low byte is the data response. It is 0x0D when `blk_len_ok`=0, else 0x0B on a CRC mismatch, else 0x05.
- R6: After a 0x05 response, `prog_start` pulses once and the card sends 0x00 bytes with `card_busy`=1 until `prog_done`. After that, a single-block write returns to idle and sends 0xFF.
- R7: Raising `spi_cs_n` during busy tristates the output (`spi_miso_oe`=0) while `card_busy` stays 1. Reselecting the card before `prog_done` makes it send 0x00 again.
- R8: In a multi-block write, each accepted block returns to waiting for 0xFC. A stop token 0xFD received in its place ends the session; later 0xFC bytes store nothing and the output is 0xFF.
- R9: `rd_go` and `wr_go` are ignored unless the engine is idle.
- R10: After a 0x0B or 0x0D response the write session ends: no `prog_start`, `card_busy` stays 0, the output is 0xFF, and a following 0xFC stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock from host |
| spi_cs_n | input | 1 | Active-low card select |
| spi_mosi | input | 1 | Host-to-card serial data |
| spi_miso | output | 1 | Card-to-host serial data |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| rd_go | input | 1 | Start a block read (pulse) |
| rd_fail | input | 1 | Read data could not be fetched |
| rd_fail_range | input | 1 | Failure cause is an out-of-range address |
| wr_go | input | 1 | Start a write session (pulse) |
| wr_multi | input | 1 | Session is multi-block |
| blk_len_ok | input | 1 | Configured block length is the full block |
| buf_addr | output | AW | Buffer byte address |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data at `buf_addr` |
| prog_start | output | 1 | Request to program the received block |
| prog_done | input | 1 | Programming finished |
| card_busy | output | 1 | Programming in progress; reject commands |

## Verification
Reads are driven with random buffer contents, so a wrong address order or a wrong CRC seed shows up in the data comparison and in the two CRC bytes. Writes are driven with random payloads in three forms: with a correct CRC, with a CRC that has one bit flipped, and with the length setting cleared. The three response codes and their precedence are each seen once. A multi-block session is followed by a deliberate rejection and then by a stop token, so that the two ways of ending a session are told apart from the accepted-block loop. The busy phase is crossed with a deselect and a reselect, and a read request is issued while the engine is busy; this separates busy bytes that persist across a reselect from a start that is wrongly accepted.

// File: rtl/sdtok_pkg.sv
package sdtok_pkg;

  localparam logic [7:0] TOK_SINGLE = 8'hFE;
  localparam logic [7:0] TOK_MULTI  = 8'hFC;
  localparam logic [7:0] TOK_STOP   = 8'hFD;
  localparam logic [7:0] LINE_IDLE  = 8'hFF;
  localparam logic [7:0] LINE_BUSY  = 8'h00;

  localparam logic [2:0] RSP_OK   = 3'b010;
  localparam logic [2:0] RSP_CRC  = 3'b101;
  localparam logic [2:0] RSP_WERR = 3'b110;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_TOK,
    S_RD_DATA,
    S_RD_CRCH,
    S_RD_CRCL,
    S_RD_ERR,
    S_WR_TOK,
    S_WR_DATA,
    S_WR_CRCH,
    S_WR_CRCL,
    S_WR_RESP,
    S_WR_BUSY
  } eng_state_t;

  // One byte through the x^16+x^12+x^5+1 shift register, MSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                             input logic [7:0]  d);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [7:0] rsp_byte(input logic [2:0] code);
    return {4'b0000, code, 1'b1};
  endfunction

  function automatic logic [7:0] err_token(input logic range_err);
    return {4'h0, range_err, 2'b00, ~range_err};
  endfunction

endpackage

// File: rtl/spitok_link.sv
module spitok_link #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_next,
  output logic       tx_load,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       miso,
  output logic       miso_oe
);

  logic [SYNC-1:0] sck_sy, cs_sy, mosi_sy;
  logic            sck_p, cs_p;
  logic [2:0]      bitcnt;
  logic [7:0]      rx_sh, tx_sh;

  wire sck_s    = sck_sy[SYNC-1];
  wire cs_s     = cs_sy[SYNC-1];
  wire mosi_s   = mosi_sy[SYNC-1];
  wire sck_rise = sck_s & ~sck_p & ~cs_s;
  wire sck_fall = ~sck_s & sck_p & ~cs_s;
  wire sel_fall = ~cs_s & cs_p;
  wire byte_end = sck_rise & (bitcnt == 3'd7);

  assign tx_load = sel_fall | (sck_fall & (bitcnt == 3'd0));
  assign miso    = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      sck_p   <= 1'b0;
      cs_p    <= 1'b1;
    end else begin
      sck_sy  <= {sck_sy[SYNC-2:0], sck};
      cs_sy   <= {cs_sy[SYNC-2:0], cs_n};
      mosi_sy <= {mosi_sy[SYNC-2:0], mosi};
      sck_p   <= sck_s;
      cs_p    <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= 8'hFF;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      miso_oe  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_s) begin
        bitcnt  <= '0;
        miso_oe <= 1'b0;
      end else begin
        miso_oe <= 1'b1;
        if (sel_fall) begin
          tx_sh  <= tx_next;
          bitcnt <= '0;
        end
        if (sck_rise) begin
          rx_sh  <= {rx_sh[6:0], mosi_s};
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_end) begin
          rx_valid <= 1'b1;
          rx_byte  <= {rx_sh[6:0], mosi_s};
        end
        if (sck_fall) begin
          if (bitcnt == 3'd0) tx_sh <= tx_next;
          else                tx_sh <= {tx_sh[6:0], 1'b1};
        end
      end
    end
  end

  // R7: a deselected card never drives the line
  assert_tristate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso_oe);

  // R1: a received byte is only reported while selected
  assert_rx_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(!cs_s));

endmodule

// File: rtl/spitok_engine.sv
module spitok_engine
  import sdtok_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int AW        = $clog2(BLK_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          tx_load,
  output logic [7:0]    tx_next,
  input  logic          rd_go,
  input  logic          rd_fail,
  input  logic          rd_fail_range,
  input  logic          wr_go,
  input  logic          wr_multi,
  input  logic          blk_len_ok,
  output logic [AW-1:0] buf_addr,
  output logic          buf_we,
  output logic [7:0]    buf_wdata,
  input  logic [7:0]    buf_rdata,
  output logic          prog_start,
  input  logic          prog_done,
  output logic          card_busy
);

  localparam logic [AW-1:0] LAST = AW'(BLK_BYTES - 1);

  eng_state_t    st;
  logic [AW-1:0] cnt;
  logic [15:0]   crc;
  logic [7:0]    crc_hi;
  logic [7:0]    resp;
  logic [7:0]    errtok;
  logic          multi;

  // named internal events
  wire blk_last   = (cnt == LAST);
  wire start_hit  = rx_valid & (multi ? (rx_byte == TOK_MULTI) : (rx_byte == TOK_SINGLE));
  wire stop_hit   = rx_valid & multi & (rx_byte == TOK_STOP);
  wire resp_ok    = (resp[3:1] == RSP_OK);
  wire crc_match  = ({crc_hi, rx_byte} == crc);
  wire data_take  = rx_valid & (st == S_WR_DATA);

  assign buf_addr  = cnt;
  assign buf_we    = data_take;
  assign buf_wdata = rx_byte;
  assign card_busy = (st == S_WR_BUSY);

  always_comb begin
    unique case (st)
      S_RD_TOK:  tx_next = TOK_SINGLE;
      S_RD_DATA: tx_next = buf_rdata;
      S_RD_CRCH: tx_next = crc[15:8];
      S_RD_CRCL: tx_next = crc[7:0];
      S_RD_ERR:  tx_next = errtok;
      S_WR_RESP: tx_next = resp;
      S_WR_BUSY: tx_next = LINE_BUSY;
      default:   tx_next = LINE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      crc        <= '0;
      crc_hi     <= '0;
      resp       <= LINE_IDLE;
      errtok     <= '0;
      multi      <= 1'b0;
      prog_start <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (rd_go) begin
            errtok <= err_token(rd_fail_range);
            st     <= rd_fail ? S_RD_ERR : S_RD_TOK;
          end else if (wr_go) begin
            multi <= wr_multi;
            st    <= S_WR_TOK;
          end
        end
        S_RD_TOK: if (tx_load) begin
          st  <= S_RD_DATA;
          cnt <= '0;
          crc <= '0;
        end
        S_RD_DATA: if (tx_load) begin
          crc <= crc16_step(crc, buf_rdata);
          cnt <= cnt + 1'b1;
          if (blk_last) st <= S_RD_CRCH;
        end
        S_RD_CRCH: if (tx_load) st <= S_RD_CRCL;
        S_RD_CRCL: if (tx_load) st <= S_IDLE;
        S_RD_ERR:  if (tx_load) st <= S_IDLE;
        S_WR_TOK: begin
          if (start_hit) begin
            st  <= S_WR_DATA;
            cnt <= '0;
            crc <= '0;
          end else if (stop_hit) begin
            st <= S_IDLE;
          end
        end
        S_WR_DATA: if (rx_valid) begin
          crc <= crc16_step(crc, rx_byte);
          cnt <= cnt + 1'b1;
          if (blk_last) st <= S_WR_CRCH;
        end
        S_WR_CRCH: if (rx_valid) begin
          crc_hi <= rx_byte;
          st     <= S_WR_CRCL;
        end
        S_WR_CRCL: if (rx_valid) begin
          if (!blk_len_ok)     resp <= rsp_byte(RSP_WERR);
          else if (!crc_match) resp <= rsp_byte(RSP_CRC);
          else                 resp <= rsp_byte(RSP_OK);
          st <= S_WR_RESP;
        end
        S_WR_RESP: if (tx_load) begin
          if (resp_ok) begin
            st         <= S_WR_BUSY;
            prog_start <= 1'b1;
          end else begin
            st <= S_IDLE;
          end
        end
        S_WR_BUSY: if (prog_done) st <= multi ? S_WR_TOK : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: only the three defined response codes are ever queued
  assert_rsp_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR_RESP) |-> (resp == 8'h05 || resp == 8'h0B || resp == 8'h0D));

  // R6: busy is held until programming reports done
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (card_busy && !prog_done) |=> card_busy);

  // R6: a programming request only accompanies entry into busy
  assert_prog_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (card_busy && !$past(card_busy)));

  // R4: the CRC phase is entered only after the last block address was written
  assert_blk_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_WR_CRCH) && $past(st == S_WR_DATA)) |-> $past(buf_we && buf_addr == LAST));

  // R9: a start pulse outside idle leaves a busy engine busy
  assert_go_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (card_busy && !prog_done && (rd_go || wr_go)) |=> card_busy);

endmodule

// File: rtl/sd_spi_token_engine.sv
module sd_spi_token_engine #(
  parameter int BLK_BYTES = 512,
  parameter int SYNC      = 2,
  parameter int AW        = $clog2(BLK_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          rd_go,
  input  logic          rd_fail,
  input  logic          rd_fail_range,
  input  logic          wr_go,
  input  logic          wr_multi,
  input  logic          blk_len_ok,
  output logic [AW-1:0] buf_addr,
  output logic          buf_we,
  output logic [7:0]    buf_wdata,
  input  logic [7:0]    buf_rdata,
  output logic          prog_start,
  input  logic          prog_done,
  output logic          card_busy
);

  logic [7:0] tx_next;
  logic       tx_load;
  logic       rx_valid;
  logic [7:0] rx_byte;

  spitok_link #(.SYNC(SYNC)) link_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .tx_next  (tx_next),
    .tx_load  (tx_load),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe)
  );

  spitok_engine #(.BLK_BYTES(BLK_BYTES), .AW(AW)) eng_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_byte       (rx_byte),
    .tx_load       (tx_load),
    .tx_next       (tx_next),
    .rd_go         (rd_go),
    .rd_fail       (rd_fail),
    .rd_fail_range (rd_fail_range),
    .wr_go         (wr_go),
    .wr_multi      (wr_multi),
    .blk_len_ok    (blk_len_ok),
    .buf_addr      (buf_addr),
    .buf_we        (buf_we),
    .buf_wdata     (buf_wdata),
    .buf_rdata     (buf_rdata),
    .prog_start    (prog_start),
    .prog_done     (prog_done),
    .card_busy     (card_busy)
  );

endmodule

// File: tb/sd_spi_token_engine_tb_top.sv
`timescale 1ns/1ps
module sd_spi_token_engine_tb_top;

  localparam int BLK  = 512;
  localparam int AW   = $clog2(BLK);
  localparam int HALF = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b1;
  logic          spi_miso, spi_miso_oe;
  logic          rd_go = 1'b0, rd_fail = 1'b0, rd_fail_range = 1'b0;
  logic          wr_go = 1'b0, wr_multi = 1'b0, blk_len_ok = 1'b1;
  logic [AW-1:0] buf_addr;
  logic          buf_we;
  logic [7:0]    buf_wdata, buf_rdata;
  logic          prog_start, prog_done = 1'b0, card_busy;

  sd_spi_token_engine #(.BLK_BYTES(BLK)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .rd_go(rd_go), .rd_fail(rd_fail), .rd_fail_range(rd_fail_range),
    .wr_go(wr_go), .wr_multi(wr_multi), .blk_len_ok(blk_len_ok),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .prog_start(prog_start), .prog_done(prog_done),
    .card_busy(card_busy)
  );

  // buffer model and event counters
  logic [7:0] mem [BLK];
  logic [7:0] pay [BLK];
  int n_we = 0, n_prog = 0;
  assign buf_rdata = mem[buf_addr];
  always @(posedge clk) begin
    if (buf_we) begin mem[buf_addr] <= buf_wdata; n_we <= n_we + 1; end
    if (prog_start) n_prog <= n_prog + 1;
  end

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // CRC over a byte list, bit stream form: shift in each data bit at the top
  function automatic logic [15:0] ref_crc(input logic [7:0] b [BLK]);
    logic [15:0] r = 16'h0000;
    for (int k = 0; k < BLK; k++)
      for (int j = 7; j >= 0; j--)
        r = {r[14:0], 1'b0} ^ ((r[15] ^ b[k][j]) ? 16'h1021 : 16'h0000);
    return r;
  endfunction

  function automatic logic [7:0] ref_resp(input bit len_ok, input bit crc_ok);
    if (!len_ok) return 8'h0D;
    if (!crc_ok) return 8'h0B;
    return 8'h05;
  endfunction

  task automatic xfer(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = o[b];
      repeat (HALF) @(negedge clk);
      i[b] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic sel();
    spi_cs_n = 1'b0;
    repeat (HALF + 1) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_rd(input bit fail, input bit rng);
    rd_fail = fail; rd_fail_range = rng; rd_go = 1'b1;
    @(negedge clk); rd_go = 1'b0;
  endtask

  task automatic pulse_wr(input bit m);
    wr_multi = m; wr_go = 1'b1;
    @(negedge clk); wr_go = 1'b0;
  endtask

  task automatic pulse_done();
    prog_done = 1'b1; @(negedge clk); prog_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // send token, random block and CRC (optionally corrupted); return the response byte
  task automatic send_block(input logic [7:0] tok, input bit bad_crc, output logic [7:0] rsp);
    logic [7:0] d;
    logic [15:0] c;
    for (int k = 0; k < BLK; k++) pay[k] = 8'($urandom);
    c = ref_crc(pay);
    if (bad_crc) c = c ^ 16'h0010;
    xfer(tok, d);
    for (int k = 0; k < BLK; k++) xfer(pay[k], d);
    xfer(c[15:8], d);
    xfer(c[7:0], d);
    xfer(8'hFF, rsp);
  endtask

  function automatic int mem_mismatch();
    int n = 0;
    for (int k = 0; k < BLK; k++) if (mem[k] !== pay[k]) n++;
    return n;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [15:0] c;
    int bad, we0;
    bit rng;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(spi_miso_oe == 1'b0, "R1 oe after reset", spi_miso_oe, 0);
    chk(card_busy == 1'b0, "R1 busy after reset", card_busy, 0);
    chk(prog_start == 1'b0, "R1 prog_start after reset", prog_start, 0);

    // R1 idle output
    sel();
    chk(spi_miso_oe == 1'b1, "R1 oe while selected", spi_miso_oe, 1);
    xfer(8'h5A, r);
    chk(r == 8'hFF, "R1 idle byte", r, 8'hFF);
    desel();

    // R2 successful read of random buffer contents
    for (int k = 0; k < BLK; k++) begin mem[k] = 8'($urandom); pay[k] = mem[k]; end
    pulse_rd(1'b0, 1'b0);
    sel();
    xfer(8'hFF, r);
    chk(r == 8'hFE, "R2 start token", r, 8'hFE);
    bad = 0;
    for (int k = 0; k < BLK; k++) begin xfer(8'hFF, r); if (r !== pay[k]) bad++; end
    chk(bad == 0, "R2 read data mismatches", bad, 0);
    c = ref_crc(pay);
    xfer(8'hFF, r);
    chk(r == c[15:8], "R2 crc high", r, c[15:8]);
    xfer(8'hFF, r);
    chk(r == c[7:0], "R2 crc low", r, c[7:0]);
    xfer(8'hFF, r);
    chk(r == 8'hFF, "R2 idle after crc", r, 8'hFF);
    desel();

    // R3 read error tokens, both causes
    for (int t = 0; t < 2; t++) begin
      rng = (t == 1);
      pulse_rd(1'b1, rng);
      sel();
      xfer(8'hFF, r);
      chk(r == (rng ? 8'h08 : 8'h01), "R3 error token", r, rng ? 8'h08 : 8'h01);
      xfer(8'hFF, r);
      chk(r == 8'hFF, "R3 idle after token", r, 8'hFF);
      desel();
    end
    rd_fail = 1'b0;

    // R4/R5/R6/R7/R9 single-block write accepted
    blk_len_ok = 1'b1;
    pulse_wr(1'b0);
    sel();
    xfer(8'hFF, r);
    xfer(8'hFC, r);                 // not the single-block token: ignored
    pulse_rd(1'b0, 1'b0);           // R9: not idle, ignored
    we0 = n_we;
    send_block(8'hFE, 1'b0, r);
    chk(r == ref_resp(1'b1, 1'b1), "R5 accepted response", r, 8'h05);
    chk(n_we - we0 == BLK, "R4 buffer write count", n_we - we0, BLK);
    chk(mem_mismatch() == 0, "R4 buffer contents", mem_mismatch(), 0);
    xfer(8'hFF, r);
    chk(r == 8'h00, "R6 busy byte", r, 8'h00);
    chk(n_prog == 1, "R6 prog_start pulses", n_prog, 1);
    chk(card_busy == 1'b1, "R6 busy flag", card_busy, 1);
    pulse_rd(1'b0, 1'b0);           // R9: busy, ignored
    desel();
    chk(spi_miso_oe == 1'b0, "R7 tristate when deselected", spi_miso_oe, 0);
    chk(card_busy == 1'b1, "R7 busy kept while deselected", card_busy, 1);
    sel();
    xfer(8'hFF, r);
    chk(r == 8'h00, "R7 busy after reselect", r, 8'h00);
    desel();
    pulse_done();
    chk(card_busy == 1'b0, "R6 busy cleared", card_busy, 0);
    sel();
    xfer(8'hFF, r);
    chk(r == 8'hFF, "R9 idle after done, no stray read", r, 8'hFF);
    desel();

    // R5/R10 CRC error on a single-block write
    pulse_wr(1'b0);
    sel();
    send_block(8'hFE, 1'b1, r);
    chk(r == ref_resp(1'b1, 1'b0), "R5 crc error response", r, 8'h0B);
    xfer(8'hFF, r);
    chk(r == 8'hFF, "R10 idle after crc error", r, 8'hFF);
    chk(n_prog == 1, "R10 no programming on crc error", n_prog, 1);
    chk(card_busy == 1'b0, "R10 not busy after crc error", card_busy, 0);
    desel();

    // R8 multi-block: one accepted block, then a length error ends it
    pulse_wr(1'b1);
    sel();
    xfer(8'hFE, r);                 // single token ignored in a multi session
    send_block(8'hFC, 1'b0, r);
    chk(r == 8'h05, "R8 multi block accepted", r, 8'h05);
    xfer(8'hFF, r);
    chk(r == 8'h00, "R8 multi busy", r, 8'h00);
    desel();
    pulse_done();
    sel();
    xfer(8'hFF, r);
    chk(r == 8'hFF, "R8 waiting for next token", r, 8'hFF);
    blk_len_ok = 1'b0;
    send_block(8'hFC, 1'b0, r);
    chk(r == ref_resp(1'b0, 1'b1), "R5 length error response", r, 8'h0D);
    blk_len_ok = 1'b1;
    we0 = n_we;
    xfer(8'hFC, r);
    chk(r == 8'hFF, "R10 idle after rejected block", r, 8'hFF);
    xfer(8'h11, r);
    xfer(8'h22, r);
    chk(n_we == we0, "R10 no store after rejection", n_we - we0, 0);
    chk(n_prog == 2, "R10 prog count after rejection", n_prog, 2);
    desel();

    // R8 stop token ends a multi session
    pulse_wr(1'b1);
    sel();
    xfer(8'hFF, r);
    xfer(8'hFD, r);
    we0 = n_we;
    xfer(8'hFC, r);
    xfer(8'h33, r);
    chk(r == 8'hFF, "R8 output after stop", r, 8'hFF);
    chk(n_we == we0, "R8 no store after stop", n_we - we0, 0);
    desel();
    pulse_rd(1'b1, 1'b1);
    sel();
    xfer(8'hFF, r);
    chk(r == 8'h08, "R8 idle again after stop", r, 8'h08);
    desel();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule